// File: doc/BRIEF.md
# Fourth-Order Recursive Fixed-Point Filter

This block is a streaming fourth-order recursive (IIR) filter built in Direct Form I. For each accepted input sample it forms nine constant products. Five act on the newest input and the four inputs before it, and four act on the four most recent outputs. The nine products are summed into one 16-bit output sample. That output is also written back into the filter's own output history, so it takes part in the next sample's computation.

Each product is brought onto a shared 20-bit grid by a fixed right shift chosen for its tap. That grid carries four bits below the output LSB. Arithmetic on the grid wraps modulo 2^20 and never saturates. This is safe because the true result always fits the output format, so any intermediate overflow cancels out in the final sum.

Samples arrive with a valid strobe, one at most per clock, and the result appears with its own valid strobe. Input samples use 11 fraction bits. Output samples use 10 fraction bits.

Top module: `dfi_iir4`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next cycle shows `out_valid` = 0 and `out_sample` = 0. Both histories are cleared to zero.
- R2: `out_valid` is high in the cycle that follows each cycle in which `in_valid` was high. It is low after every cycle in which `in_valid` was low.
- R3: Each tap multiplies its 16-bit two's-complement sample by a constant. It then shifts the product right arithmetically by a fixed amount:
  - newest input: 22280, shift 21
  - input one back: 22280, shift 19
  - input two back: 16710, shift 18
  - input three back: 22280, shift 19
  - input four back: 22280, shift 21
  - output one back: 23520, shift 9
  - output two back: -26282, shift 9
  - output three back: 26781, shift 10
  - output four back: -20887, shift 12
- R4: The nine shifted products are each truncated to 20 bits and added modulo 2^20. No overflow detection or saturation is applied.
- R5: The output sample is bits 19 down to 4 of the 20-bit total, which is the total shifted right by 4 and kept to 16 bits.
- R6: Cycles with `in_valid` low leave both histories unchanged. A sample stream with idle gaps yields the same outputs as the same stream applied back to back.
- R7: Each new output enters the output history at the same edge at which it appears on `out_sample`. The input history shifts the accepted sample in at that same edge.
- R8: `out_sample` holds its value through cycles in which no new result is produced.
- R9: A reset applied in the middle of a stream clears all history, so the following samples behave as they would from power-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Marks `in_sample` as a new sample this cycle |
| in_sample | input | 16 | Input sample, two's complement, 11 fraction bits |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| out_sample | output | 16 | Filtered output, two's complement, 10 fraction bits |

## Verification
The assertions take for granted only that `in_valid` is a clean one-bit strobe sampled while reset is released. They do not assume any bound on the data. The expected outputs are taken from an integer reference that applies the same per-tap shifts and the 20-bit wrap.

The stimulus keeps general-signal input within roughly plus or minus 13 in real terms, which is what the coefficient set was scaled for. It also drives full-scale extreme samples on purpose, so that products and partial sums overflow the grid and the wrap behaviour is exercised. Idle gaps are mixed in to show that history advances only on accepted samples.

// File: rtl/dfi_pkg.sv
// Shared constants for the fourth-order recursive filter.
// Assumes tap order: 0..4 are input delays 0..4, 5..8 are output delays 1..4.
package dfi_pkg;
    localparam int SAMPLE_W = 16;
    localparam int ACC_W    = 20;
    localparam int GUARD    = ACC_W - SAMPLE_W;   // bits below the output LSB
    localparam int ORDER    = 4;
    localparam int N_IN_TAP = ORDER + 1;
    localparam int N_TAP    = N_IN_TAP + ORDER;

    // Constant multiplier for tap idx.
    function automatic int tap_coef(input int idx);
        case (idx)
            0, 1, 3, 4: return 22280;
            2:          return 16710;
            5:          return 23520;
            6:          return -26282;
            7:          return 26781;
            default:    return -20887;
        endcase
    endfunction

    // Right-shift amount that lands tap idx on the common grid.
    function automatic int tap_shift(input int idx);
        case (idx)
            0, 4:    return 21;
            1, 3:    return 19;
            2:       return 18;
            5, 6:    return 9;
            7:       return 10;
            default: return 12;
        endcase
    endfunction
endpackage

// File: rtl/dfi_history.sv
// Delay line of DEPTH words that advances only when shift_en is high.
// taps[0] is the most recent word. Assumes a synchronous active-low reset.
module dfi_history #(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    shift_en,
    input  logic [W-1:0]            din,
    output logic [DEPTH-1:0][W-1:0] taps
);
    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_stage
            logic [W-1:0] src;
            if (g == 0) begin : g_head
                assign src = din;
            end else begin : g_body
                assign src = taps[g-1];
            end
            // Stage g: clear on reset, take the previous stage on a shift.
            always_ff @(posedge clk) begin
                if (!rst_n)        taps[g] <= '0;
                else if (shift_en) taps[g] <= src;
            end
        end
    endgenerate

    // R6: no shift leaves the whole line untouched.
    p_hist_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(taps));
    // R7: an accepted word lands at the head of the line.
    p_hist_head_r7: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> taps[0] == $past(din));
endmodule

// File: rtl/dfi_tap.sv
// One constant-coefficient tap: signed product, arithmetic right shift,
// truncated to the ACC_W-bit wrap grid. Purely combinational.
module dfi_tap #(
    parameter int SW    = 16,
    parameter int AW    = 20,
    parameter int COEF  = 1,
    parameter int SHIFT = 0
) (
    input  logic [SW-1:0] sample,
    output logic [AW-1:0] term
);
    localparam int PW = 2 * SW;
    localparam logic signed [PW-1:0] C_EXT = PW'(COEF);

    logic signed [PW-1:0] prod;

    // Full-precision signed product; both operands sign-extended to PW.
    assign prod = C_EXT * $signed({{SW{sample[SW-1]}}, sample});
    // Discard low bits by the tap shift, keep AW bits modulo 2^AW.
    assign term = AW'(prod >>> SHIFT);
endmodule

// File: rtl/dfi_wrap_sum.sv
// Adds N terms modulo 2^AW with a linear chain. Overflow is allowed to wrap:
// assumes the true total fits the final format so wraps cancel.
module dfi_wrap_sum #(
    parameter int N  = 9,
    parameter int AW = 20
) (
    input  logic [N-1:0][AW-1:0] terms,
    output logic [AW-1:0]        total
);
    logic [N:0][AW-1:0] part;

    assign part[0] = '0;
    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_add
            // Running sum step g, carry out of bit AW-1 dropped.
            assign part[g+1] = part[g] + terms[g];
        end
    endgenerate
    assign total = part[N];
endmodule

// File: rtl/dfi_iir4.sv
// Fourth-order Direct Form I recursive filter on a 20-bit wrapping grid.
// Assumes at most one sample per clock; the result registers one cycle later
// and is fed back into the output history at the same edge.
module dfi_iir4
    import dfi_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [15:0] in_sample,
    output logic        out_valid,
    output logic [15:0] out_sample
);
    logic [ORDER-1:0][SAMPLE_W-1:0] x_taps;
    logic [ORDER-1:0][SAMPLE_W-1:0] y_taps;
    logic [N_TAP-1:0][SAMPLE_W-1:0] tap_in;
    logic [N_TAP-1:0][ACC_W-1:0]    terms;
    logic [ACC_W-1:0]               acc;
    logic [SAMPLE_W-1:0]            y_next;

    // Past inputs.
    dfi_history #(.W(SAMPLE_W), .DEPTH(ORDER)) u_hist_x (
        .clk(clk), .rst_n(rst_n), .shift_en(in_valid),
        .din(in_sample), .taps(x_taps));

    // Past outputs, fed from the value being produced.
    dfi_history #(.W(SAMPLE_W), .DEPTH(ORDER)) u_hist_y (
        .clk(clk), .rst_n(rst_n), .shift_en(in_valid),
        .din(y_next), .taps(y_taps));

    // Route the current sample and both histories to their taps.
    assign tap_in[0] = in_sample;
    genvar g;
    generate
        for (g = 0; g < ORDER; g++) begin : g_route
            assign tap_in[1+g]        = x_taps[g];
            assign tap_in[N_IN_TAP+g] = y_taps[g];
        end
        for (g = 0; g < N_TAP; g++) begin : g_tap
            dfi_tap #(.SW(SAMPLE_W), .AW(ACC_W),
                      .COEF(tap_coef(g)), .SHIFT(tap_shift(g))) u_tap (
                .sample(tap_in[g]), .term(terms[g]));
        end
    endgenerate

    dfi_wrap_sum #(.N(N_TAP), .AW(ACC_W)) u_sum (
        .terms(terms), .total(acc));

    // Drop the guard bits to reach the output grid.
    assign y_next = SAMPLE_W'(acc >> GUARD);

    // Output register and strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_sample <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_sample <= y_next;
        end
    end

    // R1: reset clears the output side.
    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_sample == '0));
    // R2: one-cycle latency from accepted sample to result strobe.
    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R7: the emitted result is the newest output history entry.
    p_feedback_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> y_taps[0] == out_sample);
    // R8: output holds while no sample is accepted.
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_sample));
endmodule

// File: tb/sim_dfi_iir4.sv
`timescale 1ns/1ps
module sim_dfi_iir4;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_sample = '0;
    logic        out_valid;
    logic [15:0] out_sample;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // Reference histories: index 0 is the most recent.
    int rx[4];
    int ry[4];

    always #4 clk = ~clk;

    dfi_iir4 u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid),
                 .in_sample(in_sample), .out_valid(out_valid),
                 .out_sample(out_sample));

    function automatic longint term_of(int c, int s, int smp);
        longint p;
        p = longint'(c) * longint'(smp);
        p = p >>> s;
        return p & 64'hFFFFF;
    endfunction

    function automatic int sx16(longint v);
        longint t;
        t = v & 64'hFFFF;
        if (t >= 32768) t = t - 65536;
        return int'(t);
    endfunction

    // Reference step following R3, R4, R5; updates histories per R6/R7.
    function automatic int ref_step(int u);
        longint acc;
        int y;
        acc = 0;
        acc += term_of(22280, 21, u);
        acc += term_of(22280, 19, rx[0]);
        acc += term_of(16710, 18, rx[1]);
        acc += term_of(22280, 19, rx[2]);
        acc += term_of(22280, 21, rx[3]);
        acc += term_of(23520, 9, ry[0]);
        acc += term_of(-26282, 9, ry[1]);
        acc += term_of(26781, 10, ry[2]);
        acc += term_of(-20887, 12, ry[3]);
        acc = acc & 64'hFFFFF;
        y = sx16(acc >> 4);
        for (int i = 3; i > 0; i--) begin
            rx[i] = rx[i-1];
            ry[i] = ry[i-1];
        end
        rx[0] = u;
        ry[0] = y;
        return y;
    endfunction

    function automatic void ref_clear();
        for (int i = 0; i < 4; i++) begin
            rx[i] = 0;
            ry[i] = 0;
        end
    endfunction

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Apply one sample, then check strobe and value a cycle later.
    task automatic apply(int u, string req);
        int e;
        e = ref_step(u);
        in_valid  = 1'b1;
        in_sample = 16'(u);
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " valid"}, int'(out_valid), 1);
        check(req, sx16(longint'(out_sample)), e);
    endtask

    task automatic idle(int n, string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check({req, " idle-valid"}, int'(out_valid), 0);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        ref_clear();
    endtask

    // R1: reset state at the ports.
    task automatic t_reset();
        do_reset();
        check("R1 out_valid", int'(out_valid), 0);
        check("R1 out_sample", int'(out_sample), 0);
    endtask

    // R3/R7: impulse walks through every input tap and the feedback taps.
    task automatic t_impulse();
        apply(26624, "R3 impulse");
        for (int i = 0; i < 12; i++) apply(0, "R7 impulse tail");
    endtask

    // R3/R5: general signal within the design range, back to back.
    task automatic t_signal();
        for (int i = 0; i < 200; i++)
            apply(int'($urandom_range(0, 53248)) - 26624, "R5 signal");
    endtask

    // R4: full-scale samples force wraps on the grid.
    task automatic t_wrap();
        do_reset();
        for (int i = 0; i < 40; i++)
            apply((i % 2 == 0) ? 32767 : -32768, "R4 wrap");
        apply(-32768, "R4 wrap");
        apply(-32768, "R4 wrap");
    endtask

    // R6/R8/R2: idle gaps change neither history nor output.
    task automatic t_gaps();
        logic [15:0] held;
        do_reset();
        for (int i = 0; i < 30; i++) begin
            apply(int'($urandom_range(0, 40000)) - 20000, "R6 gapped");
            held = out_sample;
            idle(1 + (i % 3), "R2");
            check("R8 hold", int'(out_sample), int'(held));
        end
    endtask

    // R9: reset in mid-stream then an impulse behaves as from power-up.
    task automatic t_midreset();
        for (int i = 0; i < 10; i++) apply(9000 - i * 1500, "R9 pre");
        do_reset();
        check("R9 cleared", int'(out_sample), 0);
        apply(20000, "R9 impulse");
        for (int i = 0; i < 6; i++) apply(0, "R9 tail");
    endtask

    initial begin
        ref_clear();
        @(negedge clk);
        t_reset();
        t_impulse();
        t_signal();
        t_wrap();
        t_gaps();
        t_midreset();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule